// File: doc/BRIEF.md
# Event-Triggered Register-Write Replay Engine

The engine walks a list of register writes held in memory and plays it out onto a register write port whenever an armed event fires. Software places the list in memory as consecutive eight-byte entries and points the engine at it. The configuration is a start byte address, an inclusive end byte address (the last byte of the list), a write-direction flag, an address-increment flag and a two-bit event selector. When the selected event arrives, the engine fetches each entry's two words, the target address and then the value. It issues one register write per entry, in list order, and raises a completion interrupt that software clears.

The channel stays armed after a replay, so every later occurrence of the selected event replays the list again from its start. This lets a display pipeline reprogram a set of registers on every frame or line boundary without help from the processor. Memory reads use a valid/ready request with a single response strobe. Register writes use a valid/ready port. A stall on either side holds the engine in place without losing an entry.

The sequencer has six states. **IDLE** waits for an event. **FETCH_REG** requests the address word and **WAIT_REG** takes its response. **FETCH_VAL** requests the value word and **WAIT_VAL** takes its response. **ISSUE** presents the register write. The transitions are as follows:
- IDLE→FETCH_REG on an accepted event with a legal configuration.
- FETCH_REG→WAIT_REG and FETCH_VAL→WAIT_VAL on request acceptance.
- WAIT_REG→FETCH_VAL and WAIT_VAL→ISSUE on response.
- ISSUE→FETCH_REG when a write is accepted and more entries follow.
- ISSUE→IDLE when the write of the final entry is accepted.
- Any state→IDLE on a software reset.

Top module: `regwr_replay_engine`

## Requirements
- R1: For each entry at byte address B, the word at B is driven as `reg_wr_addr` and the word at B+4 as `reg_wr_data` of exactly one register write.
- R2: Entries are replayed in ascending order from `cfg_start`. The replay stops after the entry whose last byte is `cfg_end`, so a list of N entries uses exactly 2N memory reads and N writes.
- R3: `cfg_trig` encodings are 0 = disarmed (all events ignored), 1 = `frame_sync`, 2 = `line_match` and 3 = `manual_kick`. Only the selected source starts a replay.
- R4: An event is refused when any of the following holds: `cfg_start` > `cfg_end`, a span (`cfg_end`−`cfg_start`+1) that is not a multiple of 8, a span above 4096 bytes, `cfg_write`=0, or `cfg_addr_inc`=1. A refused event makes no memory request and sets the sticky `err_cfg`.
- R5: `irq` rises the cycle after the final write is accepted and stays high until `irq_clear`. If completion and clear land in the same cycle, completion wins.
- R6: The channel stays armed after completion, and a later event replays the list again from `cfg_start`.
- R7: A selected event arriving while a replay runs does not restart or alter it, and sets the sticky `overrun`.
- R8: While `mem_req_ready` or `reg_wr_ready` is low, the matching valid stays high and its address and data stay stable. No entry is lost or repeated.
- R9: A `sw_reset` pulse puts the engine in IDLE on the next cycle, abandons any replay and clears `irq`, `err_cfg` and `overrun`.
- R10: `busy` is high from the cycle after an accepted event until the cycle after the final write. `irq` rises in that same cycle.
- R11: The largest list of 512 entries (span 4096 bytes) is replayed in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Synchronous software reset pulse |
| irq_clear | input | 1 | Clears the completion interrupt |
| cfg_start | input | ADDR_W | First byte of the list |
| cfg_end | input | ADDR_W | Last byte of the list (inclusive) |
| cfg_trig | input | 2 | Event selector |
| cfg_write | input | 1 | Direction flag, 1 = write mode |
| cfg_addr_inc | input | 1 | Address-increment flag, must be 0 for pair lists |
| frame_sync | input | 1 | Frame sync event pulse |
| line_match | input | 1 | Line counter match event pulse |
| manual_kick | input | 1 | Manual start pulse |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | ADDR_W | Memory read byte address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | DATA_W | Read data |
| reg_wr_valid | output | 1 | Register write valid |
| reg_wr_ready | input | 1 | Register write accepted |
| reg_wr_addr | output | DATA_W | Target register address |
| reg_wr_data | output | DATA_W | Value to write |
| busy | output | 1 | Replay in progress |
| irq | output | 1 | Completion interrupt |
| err_cfg | output | 1 | Sticky configuration error |
| overrun | output | 1 | Sticky event-while-busy flag |

## Verification
The bench sweeps list lengths from one to six entries, all three event sources and stalls on both ports on and off. It also covers the 512-entry limit. A sequencer that misjudged the end comparison would issue one entry too many or too few, and a span check off by one would refuse the full 4096-byte list or accept 4104 bytes. A second event during a replay is sent to catch a design that restarts or truncates instead of flagging an overrun. A software reset is sent mid-replay to catch one that keeps writing afterwards. Stalls are applied to catch an entry dropped or duplicated when a valid is taken down early.

// File: rtl/rwr_pkg.sv
package rwr_pkg;

    localparam int ENTRY_BYTES = 8;
    localparam int WORD_BYTES  = 4;

    typedef enum logic [1:0] {
        TRIG_OFF    = 2'd0,
        TRIG_FRAME  = 2'd1,
        TRIG_LINE   = 2'd2,
        TRIG_MANUAL = 2'd3
    } trig_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_REG,
        ST_WAIT_REG,
        ST_FETCH_VAL,
        ST_WAIT_VAL,
        ST_ISSUE
    } seq_state_e;

endpackage

// File: rtl/rwr_trigger.sv
module rwr_trigger
    import rwr_pkg::*;
(
    input  logic [1:0] cfg_trig,
    input  logic       frame_sync,
    input  logic       line_match,
    input  logic       manual_kick,
    output logic       hit
);
    trig_sel_e sel;
    assign sel = trig_sel_e'(cfg_trig);

    always_comb begin
        unique case (sel)
            TRIG_OFF:    hit = 1'b0;
            TRIG_FRAME:  hit = frame_sync;
            TRIG_LINE:   hit = line_match;
            TRIG_MANUAL: hit = manual_kick;
            default:     hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/rwr_cfg_check.sv
module rwr_cfg_check
    import rwr_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int MAX_LIST_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [ADDR_W-1:0] cfg_end,
    input  logic              cfg_write,
    input  logic              cfg_addr_inc,
    output logic              cfg_ok
);
    localparam int ALIGN_W = $clog2(ENTRY_BYTES);

    logic [ADDR_W:0] span;
    assign span = {1'b0, cfg_end} - {1'b0, cfg_start} + (ADDR_W+1)'(1);

    assign cfg_ok = (cfg_end >= cfg_start)
                 && (span[ALIGN_W-1:0] == '0)
                 && (span <= (ADDR_W+1)'(MAX_LIST_BYTES))
                 && cfg_write
                 && !cfg_addr_inc;
endmodule

// File: rtl/rwr_sequencer.sv
module rwr_sequencer
    import rwr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_reset,
    input  logic              hit,
    input  logic              cfg_ok,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [ADDR_W-1:0] cfg_end,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              reg_wr_valid,
    input  logic              reg_wr_ready,
    output logic [DATA_W-1:0] reg_wr_addr,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              busy,
    output logic              done_pulse,
    output logic              err_pulse,
    output logic              ovr_pulse
);
    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] ptr_q, end_q;
    logic [DATA_W-1:0] radr_q, rdat_q;
    logic              last_entry;

    assign last_entry = (ptr_q + ADDR_W'(ENTRY_BYTES - 1)) == end_q;

    // State register and captured datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            end_q   <= '0;
            radr_q  <= '0;
            rdat_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: if (hit && cfg_ok) begin
                    ptr_q <= cfg_start;
                    end_q <= cfg_end;
                end
                ST_WAIT_REG: if (mem_rsp_valid) radr_q <= mem_rsp_data;
                ST_WAIT_VAL: if (mem_rsp_valid) rdat_q <= mem_rsp_data;
                ST_ISSUE:    if (reg_wr_ready && !last_entry)
                                 ptr_q <= ptr_q + ADDR_W'(ENTRY_BYTES);
                default: ;
            endcase
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (hit && cfg_ok)  state_d = ST_FETCH_REG;
            ST_FETCH_REG: if (mem_req_ready)  state_d = ST_WAIT_REG;
            ST_WAIT_REG:  if (mem_rsp_valid)  state_d = ST_FETCH_VAL;
            ST_FETCH_VAL: if (mem_req_ready)  state_d = ST_WAIT_VAL;
            ST_WAIT_VAL:  if (mem_rsp_valid)  state_d = ST_ISSUE;
            ST_ISSUE:     if (reg_wr_ready)
                              state_d = last_entry ? ST_IDLE : ST_FETCH_REG;
            default:      state_d = ST_IDLE;
        endcase
        if (sw_reset) state_d = ST_IDLE;
    end

    // Outputs
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_addr  = ptr_q;
        reg_wr_valid  = 1'b0;
        reg_wr_addr   = radr_q;
        reg_wr_data   = rdat_q;
        done_pulse    = 1'b0;
        err_pulse     = 1'b0;
        ovr_pulse     = 1'b0;
        busy          = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE:      err_pulse = hit && !cfg_ok;
            ST_FETCH_REG: mem_req_valid = 1'b1;
            ST_FETCH_VAL: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = ptr_q + ADDR_W'(WORD_BYTES);
            end
            ST_ISSUE: begin
                reg_wr_valid = 1'b1;
                done_pulse   = reg_wr_ready && last_entry && !sw_reset;
            end
            default: ;
        endcase
        if (state_q != ST_IDLE) ovr_pulse = hit;
    end
endmodule

// File: rtl/rwr_status.sv
module rwr_status (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_reset,
    input  logic irq_clear,
    input  logic done_pulse,
    input  logic err_pulse,
    input  logic ovr_pulse,
    output logic irq,
    output logic err_cfg,
    output logic overrun
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            err_cfg <= 1'b0;
            overrun <= 1'b0;
        end else if (sw_reset) begin
            irq     <= 1'b0;
            err_cfg <= 1'b0;
            overrun <= 1'b0;
        end else begin
            irq     <= done_pulse || (irq && !irq_clear);
            err_cfg <= err_cfg || err_pulse;
            overrun <= overrun || ovr_pulse;
        end
    end
endmodule

// File: rtl/regwr_replay_engine.sv
module regwr_replay_engine
    import rwr_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int DATA_W         = 32,
    parameter int MAX_LIST_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_reset,
    input  logic              irq_clear,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [ADDR_W-1:0] cfg_end,
    input  logic [1:0]        cfg_trig,
    input  logic              cfg_write,
    input  logic              cfg_addr_inc,
    input  logic              frame_sync,
    input  logic              line_match,
    input  logic              manual_kick,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              reg_wr_valid,
    input  logic              reg_wr_ready,
    output logic [DATA_W-1:0] reg_wr_addr,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              busy,
    output logic              irq,
    output logic              err_cfg,
    output logic              overrun
);
    logic hit, cfg_ok, done_pulse, err_pulse, ovr_pulse;

    rwr_trigger u_trig (
        .cfg_trig    (cfg_trig),
        .frame_sync  (frame_sync),
        .line_match  (line_match),
        .manual_kick (manual_kick),
        .hit         (hit)
    );

    rwr_cfg_check #(.ADDR_W(ADDR_W), .MAX_LIST_BYTES(MAX_LIST_BYTES)) u_chk_cfg (
        .cfg_start    (cfg_start),
        .cfg_end      (cfg_end),
        .cfg_write    (cfg_write),
        .cfg_addr_inc (cfg_addr_inc),
        .cfg_ok       (cfg_ok)
    );

    rwr_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_reset      (sw_reset),
        .hit           (hit),
        .cfg_ok        (cfg_ok),
        .cfg_start     (cfg_start),
        .cfg_end       (cfg_end),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .reg_wr_valid  (reg_wr_valid),
        .reg_wr_ready  (reg_wr_ready),
        .reg_wr_addr   (reg_wr_addr),
        .reg_wr_data   (reg_wr_data),
        .busy          (busy),
        .done_pulse    (done_pulse),
        .err_pulse     (err_pulse),
        .ovr_pulse     (ovr_pulse)
    );

    rwr_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_reset   (sw_reset),
        .irq_clear  (irq_clear),
        .done_pulse (done_pulse),
        .err_pulse  (err_pulse),
        .ovr_pulse  (ovr_pulse),
        .irq        (irq),
        .err_cfg    (err_cfg),
        .overrun    (overrun)
    );
endmodule

// File: rtl/rwr_checker.sv
module rwr_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_reset,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              reg_wr_valid,
    input logic              reg_wr_ready,
    input logic [DATA_W-1:0] reg_wr_addr,
    input logic [DATA_W-1:0] reg_wr_data,
    input logic              busy,
    input logic              irq
);
    a_r8_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready && !sw_reset)
        |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r8_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_valid && !reg_wr_ready && !sw_reset)
        |=> (reg_wr_valid && $stable(reg_wr_addr) && $stable(reg_wr_data)));

    a_r5_irq_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(reg_wr_valid && reg_wr_ready));

    a_r9_sw_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (!busy && !irq && !mem_req_valid && !reg_wr_valid));

    a_r10_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(sw_reset)) |-> irq);

    a_r1_one_port_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && reg_wr_valid));
endmodule

bind regwr_replay_engine rwr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rwr_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .sw_reset      (sw_reset),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .reg_wr_valid  (reg_wr_valid),
    .reg_wr_ready  (reg_wr_ready),
    .reg_wr_addr   (reg_wr_addr),
    .reg_wr_data   (reg_wr_data),
    .busy          (busy),
    .irq           (irq)
);

// File: tb/tb_regwr_replay_engine.sv
`timescale 1ns/1ps
module tb_regwr_replay_engine;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_reset = 1'b0, irq_clear = 1'b0;
    logic [AW-1:0] cfg_start = '0, cfg_end = '0;
    logic [1:0]    cfg_trig = 2'd0;
    logic          cfg_write = 1'b1, cfg_addr_inc = 1'b0;
    logic          frame_sync = 1'b0, line_match = 1'b0, manual_kick = 1'b0;
    logic          mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_rsp_data;
    logic          reg_wr_valid, reg_wr_ready;
    logic [DW-1:0] reg_wr_addr, reg_wr_data;
    logic          busy, irq, err_cfg, overrun;

    always #2 clk = ~clk;

    regwr_replay_engine dut (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .irq_clear(irq_clear),
        .cfg_start(cfg_start), .cfg_end(cfg_end), .cfg_trig(cfg_trig),
        .cfg_write(cfg_write), .cfg_addr_inc(cfg_addr_inc),
        .frame_sync(frame_sync), .line_match(line_match), .manual_kick(manual_kick),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .reg_wr_valid(reg_wr_valid),
        .reg_wr_ready(reg_wr_ready), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .busy(busy), .irq(irq),
        .err_cfg(err_cfg), .overrun(overrun)
    );

    int n_chk = 0, n_fail = 0;
    int wr_cnt = 0, mreq_cnt = 0;
    bit bp_en = 1'b0, finished = 1'b0;
    logic [15:0] lfsr;
    logic [31:0] log_a [0:1023];
    logic [31:0] log_d [0:1023];

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (a[2] == 1'b0) return {8'hA5, a[23:0]};
        return (a * 32'd2654435761) ^ 32'h0000_F00D;
    endfunction

    assign mem_req_ready = bp_en ? lfsr[3] : 1'b1;
    assign reg_wr_ready  = bp_en ? lfsr[9] : 1'b1;

    // Memory model (one-cycle response) and register sink
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
            lfsr          <= 16'hACE1;
        end else begin
            lfsr          <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_rsp_valid <= mem_req_valid && mem_req_ready;
            mem_rsp_data  <= mem_word(mem_req_addr);
            if (mem_req_valid && mem_req_ready) mreq_cnt <= mreq_cnt + 1;
            if (reg_wr_valid && reg_wr_ready) begin
                log_a[wr_cnt % 1024] <= reg_wr_addr;
                log_d[wr_cnt % 1024] <= reg_wr_data;
                wr_cnt <= wr_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fire(input logic [1:0] src);
        @(negedge clk);
        case (src)
            2'd1: frame_sync = 1'b1;
            2'd2: line_match = 1'b1;
            2'd3: manual_kick = 1'b1;
            default: ;
        endcase
        @(negedge clk);
        frame_sync = 1'b0; line_match = 1'b0; manual_kick = 1'b0;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 30000 && !irq; i++) @(negedge clk);
    endtask

    task automatic pulse_sw_reset();
        @(negedge clk); sw_reset = 1'b1;
        @(negedge clk); sw_reset = 1'b0;
    endtask

    task automatic clear_irq(input string req);
        repeat (3) @(negedge clk);
        check(irq == 1'b1, req, {31'd0, irq}, 32'd1);
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
        check(irq == 1'b0, req, {31'd0, irq}, 32'd0);
    endtask

    // Replays a list of n entries from st and checks every write.
    task automatic run_list(input logic [31:0] st, input int n, input logic [1:0] trig, input string req);
        int bw, bm;
        @(negedge clk);
        cfg_start = st; cfg_end = st + 32'(8 * n) - 32'd1; cfg_trig = trig;
        cfg_write = 1'b1; cfg_addr_inc = 1'b0;
        bw = wr_cnt; bm = mreq_cnt;
        fire(trig);
        wait_irq();
        check(irq == 1'b1, {req, " R5 irq on completion"}, {31'd0, irq}, 32'd1);
        check(busy == 1'b0, {req, " R10 idle at completion"}, {31'd0, busy}, 32'd0);
        check(wr_cnt - bw == n, {req, " R2 write count"}, 32'(wr_cnt - bw), 32'(n));
        check(mreq_cnt - bm == 2 * n, {req, " R2 read count"}, 32'(mreq_cnt - bm), 32'(2 * n));
        for (int k = 0; k < n; k++) begin
            logic [31:0] base;
            base = st + 32'(8 * k);
            check(log_a[(bw + k) % 1024] == mem_word(base), {req, " R1 address word"},
                  log_a[(bw + k) % 1024], mem_word(base));
            check(log_d[(bw + k) % 1024] == mem_word(base + 32'd4), {req, " R1 value word"},
                  log_d[(bw + k) % 1024], mem_word(base + 32'd4));
        end
        clear_irq({req, " R5 irq hold and clear"});
    endtask

    task automatic expect_refused(input logic [31:0] st, input logic [31:0] en,
                                  input bit wr, input bit inc, input string req);
        int bm;
        @(negedge clk);
        cfg_start = st; cfg_end = en; cfg_trig = 2'd3; cfg_write = wr; cfg_addr_inc = inc;
        bm = mreq_cnt;
        fire(2'd3);
        repeat (6) @(negedge clk);
        check(err_cfg == 1'b1, {req, " err_cfg set"}, {31'd0, err_cfg}, 32'd1);
        check(mreq_cnt == bm && !busy, {req, " no fetch"}, 32'(mreq_cnt - bm), 32'd0);
        pulse_sw_reset();
        check(err_cfg == 1'b0, {req, " R9 err cleared"}, {31'd0, err_cfg}, 32'd0);
        cfg_write = 1'b1; cfg_addr_inc = 1'b0;
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int bw, bm, held;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check(!busy && !irq && !err_cfg && !overrun, "R9 reset outputs",
              {28'd0, busy, irq, err_cfg, overrun}, 32'd0);
        check(!mem_req_valid && !reg_wr_valid, "R9 reset ports idle",
              {30'd0, mem_req_valid, reg_wr_valid}, 32'd0);

        // R3: disarmed and unselected sources
        cfg_start = 32'h100; cfg_end = 32'h10F; cfg_trig = 2'd0;
        bw = wr_cnt;
        fire(2'd1); fire(2'd2); fire(2'd3);
        repeat (10) @(negedge clk);
        check(wr_cnt == bw && !busy, "R3 disarmed ignores all events", 32'(wr_cnt - bw), 32'd0);
        cfg_trig = 2'd1;
        fire(2'd2); fire(2'd3);
        repeat (10) @(negedge clk);
        check(wr_cnt == bw && !busy, "R3 unselected sources ignored", 32'(wr_cnt - bw), 32'd0);

        // Sweep: length, source, stalls (R1 R2 R3 R8)
        for (int bp = 0; bp < 2; bp++) begin
            bp_en = bit'(bp);
            for (int n = 1; n <= 6; n++)
                run_list(32'h1000 + 32'(n * 256) + 32'(bp * 8), n, 2'((n % 3) + 1),
                         bp ? "R8 sweep stalled" : "R3 sweep");
        end

        // R6: stays armed, replays again from the start
        bp_en = 1'b0;
        run_list(32'h4000, 3, 2'd1, "R6 first replay");
        run_list(32'h4000, 3, 2'd1, "R6 rearmed replay");

        // R11: largest list, with stalls
        bp_en = 1'b1;
        run_list(32'h8000, 512, 2'd2, "R11 full 4096-byte list");
        bp_en = 1'b0;

        // R7: event during a replay
        @(negedge clk);
        cfg_start = 32'h5000; cfg_end = 32'h501F; cfg_trig = 2'd3;
        bw = wr_cnt; bm = mreq_cnt;
        fire(2'd3);
        repeat (2) @(negedge clk);
        fire(2'd3);
        wait_irq();
        check(overrun == 1'b1, "R7 overrun sticky", {31'd0, overrun}, 32'd1);
        check(wr_cnt - bw == 4, "R7 replay not restarted", 32'(wr_cnt - bw), 32'd4);
        check(log_a[(bw + 3) % 1024] == mem_word(32'h5018), "R7 last entry intact",
              log_a[(bw + 3) % 1024], mem_word(32'h5018));
        repeat (5) @(negedge clk);
        check(wr_cnt - bw == 4 && !busy, "R7 no late restart", 32'(wr_cnt - bw), 32'd4);
        clear_irq("R5 after overrun");
        check(overrun == 1'b1, "R7 overrun survives irq clear", {31'd0, overrun}, 32'd1);

        // R4: refused configurations
        expect_refused(32'h2000, 32'h1FF7, 1'b1, 1'b0, "R4 start above end");
        expect_refused(32'h2000, 32'h200B, 1'b1, 1'b0, "R4 span of 12");
        expect_refused(32'h2000, 32'h3007, 1'b1, 1'b0, "R4 span of 4104");
        expect_refused(32'h2000, 32'h200F, 1'b1, 1'b1, "R4 increment flag set");
        expect_refused(32'h2000, 32'h200F, 1'b0, 1'b0, "R4 read direction");
        check(overrun == 1'b0, "R9 overrun cleared by sw_reset", {31'd0, overrun}, 32'd0);

        // R9: software reset mid-replay
        @(negedge clk);
        cfg_start = 32'h6000; cfg_end = 32'h603F; cfg_trig = 2'd3;
        bw = wr_cnt;
        fire(2'd3);
        for (int i = 0; i < 200 && wr_cnt < bw + 2; i++) @(negedge clk);
        sw_reset = 1'b1;
        @(negedge clk);
        sw_reset = 1'b0;
        check(!busy && !irq, "R9 idle after sw_reset", {30'd0, busy, irq}, 32'd0);
        held = wr_cnt;
        repeat (30) @(negedge clk);
        check(wr_cnt == held && !busy, "R9 no writes after sw_reset", 32'(wr_cnt - held), 32'd0);
        run_list(32'h6000, 2, 2'd3, "R9 restart after sw_reset");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule